// File: doc/BRIEF.md
# Command-Indexed Security Responder

This block is a small host-bus security peripheral mapped at a single 32-bit word. When the host writes, the low byte of the data word becomes a command code. Each read after that returns one byte of a constant response stream picked by the command, and the read pointer moves forward by one. The streams are a short version string, a serial-number string and a key string. Two command codes share the serial string. Any other code reads as zero.

The block holds two registers: the current command and a byte index. Both clear at reset. A write whose low byte is zero is dropped, so the host can write zero without losing its place in a stream. When the index reaches the end of a stream, it stays there and further reads return zero. Read data is combinational from the current state and sits in the low byte of the bus word. The index moves at the clock edge that samples the read strobe.

Top module: `sec_cmd_responder`

## Requirements
- R1: After reset the command and the index are 0, and `rd_data` reads 0.
- R2: Only bits [7:0] of `wr_data` form the command. Bits [31:8] have no effect on the stream that is selected.
- R3: A write with `wr_data[7:0] == 8'h00` leaves the command and the index unchanged. A read strobe in the same cycle still advances the index.
- R4: A write with a nonzero low byte stores that byte as the command and sets the index to 0. This takes priority over a read strobe in the same cycle, and that read returns the byte at the index the block held before the write.
- R5: Command 8'h20 yields the 5-byte stream 00 01 00 00 00, at indices 0 to 4.
- R6: Commands 8'h21 and 8'h22 both yield the 10-byte stream 01 02 03 04 05 06 07 08 09 0A.
- R7: Command 8'h23 yields the 10-byte stream AA 55 18 18 C0 03 F0 0F 09 0A.
- R8: `rd_data` shows the byte at the current index. A cycle with `rd_en` high and no nonzero write moves the index up by one at the next clock edge, until the index reaches the end of the stream.
- R9: Under any command other than 8'h20 to 8'h23, `rd_data` is 0 and the index stays at 0.
- R10: Once the index equals the stream length, reads return 0 and the index stays at that length instead of wrapping.
- R11: Bits [31:8] of `rd_data` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe for the register word |
| wr_data | input | 32 | Host write data; the low byte is the command |
| rd_en | input | 1 | Host read strobe; advances the index |
| rd_data | output | 32 | Response byte, zero-extended |

## Verification
The directed part walks each stream to its end and beyond. It shows that the index stops at the end of the stream and that reads past the end return zero. It also tells apart codes 8'h21 and 8'h22, which share the serial stream, from their neighbours 8'h1F and 8'h24, which read zero. It writes zero partway through a stream to show that the position is kept, and it writes a nonzero code with junk in the upper bits to show that only the low byte counts. The random part mixes writes, reads, both strobes in the same cycle, and idle cycles, with commands biased toward zero and the four valid codes. Every cycle is compared with a reference model in the bench, which separates write-over-read priority from read advance.

// File: rtl/sec_resp_pkg.sv
package sec_resp_pkg;

    localparam int BUS_W  = 32;
    localparam int CMD_W  = 8;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    localparam logic [CMD_W-1:0] CMD_VERSION  = 8'h20;
    localparam logic [CMD_W-1:0] CMD_SERIAL_A = 8'h21;
    localparam logic [CMD_W-1:0] CMD_SERIAL_B = 8'h22;
    localparam logic [CMD_W-1:0] CMD_KEY      = 8'h23;

    localparam int VERSION_LEN = 5;
    localparam int SERIAL_LEN  = 10;
    localparam int KEY_LEN     = 10;

    typedef enum logic [1:0] {
        SEL_NONE    = 2'd0,
        SEL_VERSION = 2'd1,
        SEL_SERIAL  = 2'd2,
        SEL_KEY     = 2'd3
    } stream_sel_e;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [IDX_W-1:0] idx;
    } resp_state_t;

endpackage

// File: rtl/sec_cmd_decode.sv
module sec_cmd_decode
    import sec_resp_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output stream_sel_e      sel,
    output logic [IDX_W-1:0] len
);
    always_comb begin
        sel = SEL_NONE;
        len = '0;
        unique case (cmd)
            CMD_VERSION: begin
                sel = SEL_VERSION;
                len = IDX_W'(VERSION_LEN);
            end
            CMD_SERIAL_A, CMD_SERIAL_B: begin
                sel = SEL_SERIAL;
                len = IDX_W'(SERIAL_LEN);
            end
            CMD_KEY: begin
                sel = SEL_KEY;
                len = IDX_W'(KEY_LEN);
            end
            default: begin
                sel = SEL_NONE;
                len = '0;
            end
        endcase
    end
endmodule

// File: rtl/sec_stream_rom.sv
module sec_stream_rom
    import sec_resp_pkg::*;
(
    input  stream_sel_e       sel,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IDX_W-1:0]  len,
    output logic [BYTE_W-1:0] data
);
    logic [BYTE_W-1:0] key_byte;
    logic [BYTE_W-1:0] raw_byte;

    always_comb begin
        unique case (idx)
            4'd0:    key_byte = 8'hAA;
            4'd1:    key_byte = 8'h55;
            4'd2:    key_byte = 8'h18;
            4'd3:    key_byte = 8'h18;
            4'd4:    key_byte = 8'hC0;
            4'd5:    key_byte = 8'h03;
            4'd6:    key_byte = 8'hF0;
            4'd7:    key_byte = 8'h0F;
            4'd8:    key_byte = 8'h09;
            4'd9:    key_byte = 8'h0A;
            default: key_byte = 8'h00;
        endcase
    end

    always_comb begin
        unique case (sel)
            SEL_VERSION: raw_byte = (idx == IDX_W'(1)) ? 8'h01 : 8'h00;
            SEL_SERIAL:  raw_byte = BYTE_W'(idx) + 8'h01;
            SEL_KEY:     raw_byte = key_byte;
            default:     raw_byte = 8'h00;
        endcase
        data = (idx < len) ? raw_byte : 8'h00;
    end
endmodule

// File: rtl/sec_cmd_responder.sv
module sec_cmd_responder
    import sec_resp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             rd_en,
    output logic [BUS_W-1:0] rd_data
);
    resp_state_t       st_d, st_q;
    stream_sel_e       sel;
    logic [IDX_W-1:0]  len;
    logic [BYTE_W-1:0] byte_out;
    logic [CMD_W-1:0]  wr_cmd;
    logic              load;

    assign wr_cmd = wr_data[CMD_W-1:0];
    assign load   = wr_en && (wr_cmd != '0);

    sec_cmd_decode u_decode (
        .cmd (st_q.cmd),
        .sel (sel),
        .len (len)
    );

    sec_stream_rom u_rom (
        .sel  (sel),
        .idx  (st_q.idx),
        .len  (len),
        .data (byte_out)
    );

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cmd = wr_cmd;
            st_d.idx = '0;
        end else if (rd_en && (st_q.idx < len)) begin
            st_d.idx = st_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = {{(BUS_W-BYTE_W){1'b0}}, byte_out};

    // R4: a nonzero write loads the command and rewinds the index
    a_r4_load_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:0] != 8'h00) |=> (st_q.idx == '0 && st_q.cmd == $past(wr_data[7:0])));

    // R3: a zero write with no read keeps the whole state
    a_r3_zero_write_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7:0] == 8'h00 && !rd_en) |=> ($stable(st_q.cmd) && $stable(st_q.idx)));

    // R8: a plain read inside the stream advances by exactly one
    a_r8_advance_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !load && st_q.idx < len) |=> (st_q.idx == $past(st_q.idx) + IDX_W'(1)));

    // R10: the index never passes the stream length
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= len);

    // R9: an unknown command reads zero
    a_r9_unknown_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |-> (rd_data == '0));

    // R11: upper bits of the read word are zero
    a_r11_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[BUS_W-1:BYTE_W] == '0);
endmodule

// File: tb/tb_sec_cmd_responder.sv
module tb_sec_cmd_responder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] m_cmd = 8'h00;
    int         m_idx = 0;

    sec_cmd_responder dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int stream_len(input logic [7:0] c);
        case (c)
            8'h20: return 5;
            8'h21, 8'h22, 8'h23: return 10;
            default: return 0;
        endcase
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] c, input int i);
        if (i >= stream_len(c)) return 8'h00;
        case (c)
            8'h20: return (i == 1) ? 8'h01 : 8'h00;
            8'h21, 8'h22: return 8'(i + 1);
            8'h23: case (i)
                0: return 8'hAA; 1: return 8'h55; 2: return 8'h18; 3: return 8'h18;
                4: return 8'hC0; 5: return 8'h03; 6: return 8'hF0; 7: return 8'h0F;
                8: return 8'h09; default: return 8'h0A;
            endcase
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input logic [7:0] c, input int i);
        if (i >= stream_len(c) && stream_len(c) != 0) return "R10";
        case (c)
            8'h20: return "R5";
            8'h21, 8'h22: return "R6";
            8'h23: return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: rd_data=%h expected %h (cmd=%h idx=%0d)", tag, act, exp, m_cmd, m_idx);
        end
    endtask

    // one bus cycle: drive at negedge, check output, then update the model at the edge
    task automatic cycle(input logic w, input logic [31:0] wd, input logic r, input string tag);
        @(negedge clk);
        wr_en = w; wr_data = wd; rd_en = r;
        #1;
        check(tag.len() ? tag : tag_for(m_cmd, m_idx), rd_data, {24'h0, model_byte(m_cmd, m_idx)});
        if (rd_data[31:8] != 24'h0) check("R11", rd_data, {24'h0, rd_data[7:0]});
        @(posedge clk);
        if (w && wd[7:0] != 8'h00) begin
            m_cmd = wd[7:0];
            m_idx = 0;
        end else if (r && m_idx < stream_len(m_cmd)) begin
            m_idx++;
        end
        #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state reads zero
        cycle(1'b0, 32'h0, 1'b1, "R1");
        cycle(1'b0, 32'h0, 1'b0, "R1");

        // R5 version stream, walked past its end (R10)
        cycle(1'b1, 32'h20, 1'b0, "R4");
        for (int i = 0; i < 8; i++) cycle(1'b0, 32'h0, 1'b1, "");
        // R6 both serial codes
        cycle(1'b1, 32'h21, 1'b0, "R4");
        for (int i = 0; i < 12; i++) cycle(1'b0, 32'h0, 1'b1, "");
        // R2: upper bits of the write ignored
        cycle(1'b1, 32'hFFFF_FF22, 1'b0, "R2");
        for (int i = 0; i < 4; i++) cycle(1'b0, 32'h0, 1'b1, "R2");
        // R3: zero write keeps position, read in same cycle still advances
        cycle(1'b1, 32'hABCD_0000, 1'b0, "R3");
        cycle(1'b0, 32'h0, 1'b1, "R3");
        cycle(1'b1, 32'h0000_1200, 1'b1, "R3");
        cycle(1'b0, 32'h0, 1'b1, "R3");
        // R7 key stream plus overrun
        cycle(1'b1, 32'h23, 1'b0, "R4");
        for (int i = 0; i < 11; i++) cycle(1'b0, 32'h0, 1'b1, "");
        // R4: write wins over simultaneous read
        cycle(1'b1, 32'h23, 1'b0, "R4");
        cycle(1'b0, 32'h0, 1'b1, "R8");
        cycle(1'b0, 32'h0, 1'b1, "R8");
        cycle(1'b1, 32'h21, 1'b1, "R4");
        cycle(1'b0, 32'h0, 1'b1, "R4");
        // R9: neighbouring unknown codes
        cycle(1'b1, 32'h1F, 1'b0, "R9");
        cycle(1'b0, 32'h0, 1'b1, "R9");
        cycle(1'b1, 32'h24, 1'b0, "R9");
        cycle(1'b0, 32'h0, 1'b1, "R9");
        cycle(1'b0, 32'h0, 1'b1, "R9");

        // random mix (R8 and the stream requirements)
        for (int n = 0; n < 3000; n++) begin
            int op = $urandom_range(0, 9);
            int cs = $urandom_range(0, 7);
            logic [31:0] wd = {$urandom(), 8'h00} ;
            logic [7:0] c;
            case (cs)
                0, 1: c = 8'h00;
                2: c = 8'h20; 3: c = 8'h21; 4: c = 8'h22; 5: c = 8'h23;
                default: c = 8'($urandom());
            endcase
            wd[7:0] = c;
            case (op)
                0:       cycle(1'b1, wd, 1'b0, "");
                1:       cycle(1'b1, wd, 1'b1, "");
                2:       cycle(1'b0, 32'h0, 1'b0, "");
                default: cycle(1'b0, 32'h0, 1'b1, "");
            endcase
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule